// File: doc/BRIEF.md
# Microprogram Sequencer with Conditional Branching

This block drives a microprogrammed control unit. A 7-bit control address register selects one word of a 128-entry by 20-bit control store. The control store is generated from a fixed formula inside the design. The selected word is loaded into a control register on the same clock edge as the address, so the address and the microinstruction always refer to the same step. The three 3-bit operation fields of the held microinstruction are decoded into one-hot strobes for the data path that executes them.

While those strobes are active, the next-address logic works in parallel. It picks one of four status conditions: constant true, data register bit 15, accumulator sign, or accumulator zero. It then combines the result with the 2-bit branch type to choose the next address. The choices are increment, jump, subroutine call, subroutine return, or a mapped entry point built from the 4-bit instruction opcode. A single return register holds the link address for one level of subroutine.

Top module: `useq_sequencer`

## Requirements
- R1: A synchronous reset (active high `rst`) loads the control address with 64 (the fetch routine), loads the control register with the word at 64, and clears the return register to 0; `ctl_addr` shows 64 while reset is held.
- R2: Each operation field is decoded to a 7-bit one-hot strobe in which bit k-1 is set for code k (1..7); code 000 is no operation and drives all seven bits to 0.
- R3: The condition select field chooses the tested status: 00 is always true, 01 is `dr_bit15`, 10 is `acc_sign`, 11 is `acc_zero`.
- R4: Branch type 00 (jump) loads the address field when the condition is true.
- R5: Branch type 01 (call) loads the address field and stores the current address plus 1 in the return register when the condition is true. The return register is unchanged otherwise.
- R6: Branch type 10 (return) loads the return register contents when the condition is true.
- R7: Branch type 11 (map) loads {0, opcode[3:0], 00} whatever the condition.
- R8: For branch types 00, 01 and 10 with a false condition, the address becomes the current address plus 1, modulo 128.
- R9: The control store word at address a has these fields: operation field A (bits 19:17) = a[2:0]; field B (16:14) = a[5:3]; field C (13:11) = a[2:0] xor a[5:3]; condition select (10:9) = a[1:0]; branch type (8:7) = a[3:2]; address field (6:0) = (37*a + 11) mod 128.
- R10: Each clock moves the address register and the control register together, so `ctl_addr` and the strobes always describe the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dr_bit15 | input | 1 | Status: data register bit 15 |
| acc_sign | input | 1 | Status: accumulator sign bit |
| acc_zero | input | 1 | Status: accumulator equals zero |
| opcode | input | 4 | Instruction opcode used by the map branch |
| ctl_addr | output | 7 | Current control address |
| uop_a | output | 7 | One-hot strobes of operation field A |
| uop_b | output | 7 | One-hot strobes of operation field B |
| uop_c | output | 7 | One-hot strobes of operation field C |

## Verification
The sequencer runs freely through its control store. On every cycle the three status bits and the opcode are drawn at random, so each branch type meets both a true and a false condition under every select code. This separates a wrong select encoding from a wrong branch action. Random opcodes on map words show whether the opcode lands in the right address bits. Call and later return words show whether the link value is captured and restored. A reset applied in mid-run confirms that the start address and the cleared return register come back from any state.

// File: rtl/useq_pkg.sv
package useq_pkg;
    localparam int ADDR_W  = 7;
    localparam int FLD_W   = 3;
    localparam int SEL_W   = 2;
    localparam int OPC_W   = 4;
    localparam int DEC_W   = (1 << FLD_W) - 1;
    localparam int WORD_W  = 3 * FLD_W + 2 * SEL_W + ADDR_W;
    localparam int ROM_MUL = 37;
    localparam int ROM_ADD = 11;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [SEL_W-1:0] {
        BR_JUMP = 2'b00,
        BR_CALL = 2'b01,
        BR_RET  = 2'b10,
        BR_MAP  = 2'b11
    } br_e;

    typedef struct packed {
        logic [FLD_W-1:0] fa;
        logic [FLD_W-1:0] fb;
        logic [FLD_W-1:0] fc;
        logic [SEL_W-1:0] sel;
        br_e              br;
        addr_t            tgt;
    } uword_t;

    function automatic uword_t store_word(addr_t a);
        uword_t w;
        int     t;
        t      = int'(a) * ROM_MUL + ROM_ADD;
        w.fa   = a[2:0];
        w.fb   = a[5:3];
        w.fc   = a[2:0] ^ a[5:3];
        w.sel  = a[1:0];
        w.br   = br_e'(a[3:2]);
        w.tgt  = addr_t'(t);
        return w;
    endfunction
endpackage

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
(
    input  addr_t  addr,
    output uword_t word
);
    always_comb word = store_word(addr);
endmodule

// File: rtl/useq_cond_sel.sv
module useq_cond_sel
    import useq_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic             dr_bit15,
    input  logic             acc_sign,
    input  logic             acc_zero,
    output logic             hit
);
    always_comb begin
        unique case (sel)
            2'b00:   hit = 1'b1;
            2'b01:   hit = dr_bit15;
            2'b10:   hit = acc_sign;
            default: hit = acc_zero;
        endcase
    end
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
    import useq_pkg::*;
(
    input  addr_t            cur,
    input  addr_t            link,
    input  br_e              br,
    input  addr_t            tgt,
    input  logic             hit,
    input  logic [OPC_W-1:0] opcode,
    output addr_t            nxt,
    output logic             link_we
);
    localparam int MAP_SH = ADDR_W - OPC_W - 1;

    addr_t seq;
    addr_t mapped;

    always_comb begin
        seq     = addr_t'(cur + 1'b1);
        mapped  = addr_t'({opcode, {MAP_SH{1'b0}}});
        link_we = 1'b0;
        nxt     = seq;
        unique case (br)
            BR_JUMP: if (hit) nxt = tgt;
            BR_CALL: if (hit) begin
                nxt     = tgt;
                link_we = 1'b1;
            end
            BR_RET:  if (hit) nxt = link;
            default: nxt = mapped;
        endcase
    end
endmodule

// File: rtl/useq_uop_dec.sv
module useq_uop_dec
    import useq_pkg::*;
(
    input  logic [FLD_W-1:0] code,
    output logic [DEC_W-1:0] strobe
);
    for (genvar k = 0; k < DEC_W; k++) begin : g_bit
        assign strobe[k] = (code == FLD_W'(k + 1));
    end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
#(
    parameter int FETCH_ADDR = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dr_bit15,
    input  logic             acc_sign,
    input  logic             acc_zero,
    input  logic [OPC_W-1:0] opcode,
    output logic [ADDR_W-1:0] ctl_addr,
    output logic [DEC_W-1:0] uop_a,
    output logic [DEC_W-1:0] uop_b,
    output logic [DEC_W-1:0] uop_c
);
    localparam addr_t START = addr_t'(FETCH_ADDR);

    typedef struct packed {
        addr_t  car;
        addr_t  link;
        uword_t cr;
    } seq_state_t;

    seq_state_t s_d, s_q;

    logic   cond_hit;
    logic   link_we;
    addr_t  nxt_addr;
    addr_t  load_addr;
    uword_t load_word;

    useq_cond_sel u_cond (
        .sel      (s_q.cr.sel),
        .dr_bit15 (dr_bit15),
        .acc_sign (acc_sign),
        .acc_zero (acc_zero),
        .hit      (cond_hit)
    );

    useq_next_addr u_next (
        .cur     (s_q.car),
        .link    (s_q.link),
        .br      (s_q.cr.br),
        .tgt     (s_q.cr.tgt),
        .hit     (cond_hit),
        .opcode  (opcode),
        .nxt     (nxt_addr),
        .link_we (link_we)
    );

    assign load_addr = rst ? START : nxt_addr;

    useq_store u_store (
        .addr (load_addr),
        .word (load_word)
    );

    always_comb begin
        s_d      = s_q;
        s_d.car  = load_addr;
        s_d.cr   = load_word;
        if (rst)          s_d.link = '0;
        else if (link_we) s_d.link = addr_t'(s_q.car + 1'b1);
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    useq_uop_dec u_dec_a (.code(s_q.cr.fa), .strobe(uop_a));
    useq_uop_dec u_dec_b (.code(s_q.cr.fb), .strobe(uop_b));
    useq_uop_dec u_dec_c (.code(s_q.cr.fc), .strobe(uop_c));

    assign ctl_addr = s_q.car;
endmodule

// File: rtl/useq_checker.sv
module useq_checker
    import useq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input addr_t            car,
    input addr_t            link,
    input br_e              br,
    input logic             hit,
    input logic [OPC_W-1:0] opcode,
    input logic [DEC_W-1:0] uop_a,
    input logic [DEC_W-1:0] uop_b,
    input logic [DEC_W-1:0] uop_c
);
    AST_RESET_START: assert property (@(posedge clk)
        $fell(rst) |-> (car == addr_t'(64) && link == '0)); // R1

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(uop_a) && $onehot0(uop_b) && $onehot0(uop_c)); // R2

    AST_MAP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (br == BR_MAP) |=> (car == addr_t'({$past(opcode), 2'b00}))); // R7

    AST_FALSE_INCR: assert property (@(posedge clk) disable iff (rst)
        (br != BR_MAP && !hit) |=> (car == addr_t'($past(car) + 1'b1))); // R8

    AST_CALL_LINK: assert property (@(posedge clk) disable iff (rst)
        (br == BR_CALL && hit) |=> (link == addr_t'($past(car) + 1'b1))); // R5

    AST_RET_TARGET: assert property (@(posedge clk) disable iff (rst)
        (br == BR_RET && hit) |=> (car == $past(link))); // R6

    AST_LINK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(br == BR_CALL && hit) |=> $stable(link)); // R5
endmodule

bind useq_sequencer useq_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .car    (s_q.car),
    .link   (s_q.link),
    .br     (s_q.cr.br),
    .hit    (cond_hit),
    .opcode (opcode),
    .uop_a  (uop_a),
    .uop_b  (uop_b),
    .uop_c  (uop_c)
);

// File: tb/tb_useq_sequencer.sv
`timescale 1ns/1ps
module tb_useq_sequencer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dr_bit15 = 1'b0;
    logic       acc_sign = 1'b0;
    logic       acc_zero = 1'b0;
    logic [3:0] opcode = 4'd0;
    logic [6:0] ctl_addr;
    logic [6:0] uop_a, uop_b, uop_c;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int m_car  = 64;
    int m_link = 0;

    always #2.5 clk = ~clk;

    useq_sequencer dut (
        .clk(clk), .rst(rst), .dr_bit15(dr_bit15), .acc_sign(acc_sign),
        .acc_zero(acc_zero), .opcode(opcode), .ctl_addr(ctl_addr),
        .uop_a(uop_a), .uop_b(uop_b), .uop_c(uop_c)
    );

    // R2: code k -> bit k-1, code 0 -> none
    function automatic logic [6:0] onehot(int code);
        return (code == 0) ? 7'd0 : 7'(1 << (code - 1));
    endfunction

    // R9 fields of the store word at a
    function automatic int f_a(int a);   return a % 8;                endfunction
    function automatic int f_b(int a);   return (a / 8) % 8;          endfunction
    function automatic int f_c(int a);   return f_a(a) ^ f_b(a);      endfunction
    function automatic int f_sel(int a); return a % 4;                endfunction
    function automatic int f_br(int a);  return (a / 4) % 4;          endfunction
    function automatic int f_tgt(int a); return (a * 37 + 11) % 128; endfunction

    task automatic check_state(string tag);
        logic [27:0] act, exp;
        act = {ctl_addr, uop_a, uop_b, uop_c};
        exp = {7'(m_car), onehot(f_a(m_car)), onehot(f_b(m_car)), onehot(f_c(m_car))};
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s R2 R9 R10: actual addr=%0d a=%b b=%b c=%b expected addr=%0d a=%b b=%b c=%b",
                     tag, act[27:21], act[20:14], act[13:7], act[6:0],
                     exp[27:21], exp[20:14], exp[13:7], exp[6:0]);
        end
    endtask

    // R3..R8: model of one step, returns the tag of the taken path
    function automatic string step_model();
        int    sel, br;
        bit    hit;
        string tag;
        sel = f_sel(m_car);
        br  = f_br(m_car);
        case (sel)
            0: hit = 1'b1;
            1: hit = dr_bit15;
            2: hit = acc_sign;
            default: hit = acc_zero;
        endcase
        if (br == 3) begin
            tag   = "R7 map";
            m_car = int'(opcode) * 4;
        end else if (!hit) begin
            tag   = "R3 R8 incr";
            m_car = (m_car + 1) % 128;
        end else if (br == 0) begin
            tag   = "R3 R4 jump";
            m_car = f_tgt(m_car);
        end else if (br == 1) begin
            tag    = "R3 R5 call";
            m_link = (m_car + 1) % 128;
            m_car  = f_tgt(m_car);
        end else begin
            tag   = "R3 R6 return";
            m_car = m_link;
        end
        return tag;
    endfunction

    task automatic run_cycles(int n, int mode);
        string tag;
        for (int i = 0; i < n; i++) begin
            case (mode)
                0: {dr_bit15, acc_sign, acc_zero, opcode} = 7'($urandom);
                1: {dr_bit15, acc_sign, acc_zero, opcode} = {3'b000, 4'($urandom)};
                default: {dr_bit15, acc_sign, acc_zero, opcode} = {3'b111, 4'($urandom)};
            endcase
            tag = step_model();
            @(negedge clk);
            check_state(tag);
        end
    endtask

    task automatic reset_check();
        rst = 1'b1;
        @(negedge clk);
        m_car  = 64;
        m_link = 0;
        check_state("R1 reset");
        @(negedge clk);
        check_state("R1 reset held");
        rst = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        reset_check();
        run_cycles(2000, 0);      // random status and opcode
        run_cycles(300, 1);       // all conditions false except U
        run_cycles(300, 2);       // all conditions true
        reset_check();            // R1 from a running state
        run_cycles(1500, 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog R10: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule